// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

This peripheral holds a bank of independent down-counters, six by default. Each counter has its own control, reload-value and live-count registers and raises its own interrupt line. A counter advances on pulses from one of four clock-enable inputs that the surrounding chip provides. Each channel chooses its input and divides it by a power of two between 1 and 128. On expiry a counter either reloads itself and keeps running, or stops and disarms itself.

All channels share two registers: a global interrupt mask and a sticky status register. Software clears status bits by writing ones to them. A plain synchronous port carries register accesses. A write lands at the clock edge on which `wr_en` is high. A read launched with `rd_en` returns its data on `rdata` one cycle later, and `rdata` holds that value until the next read.

Top module: `pit_timer_bank`

## Requirements
- R1: `irq[i]` is high exactly when channel i's status bit and its mask bit (mask register at byte address 0x00, bit i) are both set.
- R2: Writing the status register (address 0x04) clears every bit written as 1 and keeps every bit written as 0. An expiry in the same cycle as a clearing write leaves the bit set.
- R3: Channel c (0 to 5) owns the window at 0x10*(c+1). Control is at offset 0x0, reload value at 0x4 and live count at 0x8. Read data appears on `rdata` the cycle after `rd_en`.
- R4: The control fields are: bit 0 run, bit 1 load-now (never stored, reads back 0), bits [3:2] source select, bits [6:4] prescale exponent N, bit 7 one-shot.
- R5: A running counter steps once every 2^N pulses of the selected `src_tick` bit. Pulses on the other source bits have no effect. Any control write restarts the divide.
- R6: A control write with bit 1 set loads the count from the reload register in that same write.
- R7: A control write with bit 0 clear freezes the count. A later write with bit 0 set resumes counting from the frozen value.
- R8: A step from 1 to 0 sets the channel's status bit. In periodic mode (bit 7 clear) the next step reloads the reload value, so the period is reload+1 steps.
- R9: In one-shot mode an expiry clears the channel's run bit, which then reads back as 0, and the count stays at 0.
- R10: A count read returns the live value. Writing the reload register leaves the current count unchanged, and writes to the count offset are ignored.
- R11: After reset each control register reads 0x04 (source 1, divide by 1, stopped), and the mask, the status, all reload values and all counts are 0.
- R12: Reads from unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | Clock-enable pulses, one per selectable source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 6 | Per-channel interrupt lines |

## Verification
The bench drives each source-tick bit by hand, so every count read has an exact expected value. Three separate tests single out the behaviour of one channel. Pulses on a source that is not selected show that source selection works. A divide-by-4 run, with reads taken after three pulses and after the fourth, separates prescale from plain counting. Stopping, pulsing and then resuming shows that the count freezes. Two further channels cover the two expiry modes. The periodic channel must wrap to its reload value, while the one-shot channel must sit at zero with its run bit cleared. A status write that lands on the same edge as an expiry confirms that a new event survives a clear. Mapped-looking but unused offsets, and an out-of-range channel window, confirm that decode rejects them.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int CTL_W = 8;
   localparam int PRE_W = 3;
   localparam int SRC_W = 2;

   typedef struct packed {
      logic             oneshot;
      logic [PRE_W-1:0] pre;
      logic [SRC_W-1:0] src;
      logic             load;
      logic             run;
   } ctrl_t;

   localparam logic [3:0] OFF_CTRL = 4'h0;
   localparam logic [3:0] OFF_IVL  = 4'h4;
   localparam logic [3:0] OFF_CNT  = 4'h8;
   localparam logic [7:0] ADDR_MASK = 8'h00;
   localparam logic [7:0] ADDR_STAT = 8'h04;
   localparam logic [CTL_W-1:0] CTRL_RESET = 8'h04;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
   parameter int NUM_SRC = 4,
   parameter int PRE_W   = pit_pkg::PRE_W,
   parameter int SEL_W   = pit_pkg::SRC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [SEL_W-1:0]   sel,
   input  logic [PRE_W-1:0]   pre,
   output logic               tick
);
   localparam int DIV_W = (1 << PRE_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;
   logic             src_hit;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("pit_prescale: PRE_W must be at least 1");
      end
   endgenerate

   assign mask    = (DIV_W'(1) << pre) - DIV_W'(1);
   assign src_hit = src_tick[sel];
   assign tick    = src_hit && ((div_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (restart) div_q <= '0;
      else if (src_hit) div_q <= div_q + DIV_W'(1);
   end
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
   parameter int NUM_SRC = 4,
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       src_tick,
   input  logic                     ctl_wr,
   input  logic                     ivl_wr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [pit_pkg::CTL_W-1:0] ctrl_o,
   output logic [CNT_W-1:0]         ivl_o,
   output logic [CNT_W-1:0]         cnt_o,
   output logic                     tick_o,
   output logic                     expire_o
);
   import pit_pkg::*;

   ctrl_t            ctrl_q;
   ctrl_t            wr_ctrl;
   logic [CNT_W-1:0] ivl_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   pit_prescale #(.NUM_SRC(NUM_SRC)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (ctl_wr),
      .src_tick (src_tick),
      .sel      (ctrl_q.src),
      .pre      (ctrl_q.pre),
      .tick     (tick)
   );

   always_comb begin
      wr_ctrl      = ctrl_t'(wdata[CTL_W-1:0]);
      wr_ctrl.load = 1'b0;
   end

   assign expire_o = ctrl_q.run && tick && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= ctrl_t'(CTRL_RESET);
         ivl_q  <= '0;
         cnt_q  <= '0;
      end else begin
         if (ivl_wr) ivl_q <= wdata[CNT_W-1:0];
         if (ctl_wr) begin
            ctrl_q <= wr_ctrl;
            if (wdata[1]) cnt_q <= ivl_q;
         end else if (ctrl_q.run && tick) begin
            if (cnt_q != '0)          cnt_q <= cnt_q - CNT_W'(1);
            else if (!ctrl_q.oneshot) cnt_q <= ivl_q;
            if (expire_o && ctrl_q.oneshot) ctrl_q.run <= 1'b0;
         end
      end
   end

   assign ctrl_o = ctrl_q;
   assign ivl_o  = ivl_q;
   assign cnt_o  = cnt_q;
   assign tick_o = tick;
endmodule

// File: rtl/pit_timer_bank.sv
module pit_timer_bank #(
   parameter int NUM_CH   = 6,
   parameter int NUM_SRC  = 4,
   parameter int CNT_W    = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter bit REG_READ = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic [NUM_CH-1:0]  irq
);
   import pit_pkg::*;

   generate
      if (NUM_CH < 1 || NUM_CH > 15) begin : g_bad_ch
         $error("pit_timer_bank: NUM_CH must be 1..15");
      end
      if (NUM_SRC != 4) begin : g_bad_src
         $error("pit_timer_bank: NUM_SRC must be 4");
      end
      if (CNT_W > DATA_W || DATA_W < CTL_W || NUM_CH > DATA_W) begin : g_bad_w
         $error("pit_timer_bank: data width too small");
      end
      if (ADDR_W < 8) begin : g_bad_a
         $error("pit_timer_bank: ADDR_W must be at least 8");
      end
   endgenerate

   logic [3:0]  win;
   logic [3:0]  off;
   logic        in_range;
   logic        mask_wr;
   logic        stat_wr;

   logic [NUM_CH-1:0]            ien_q;
   logic [NUM_CH-1:0]            stat_q;
   logic [NUM_CH-1:0]            clr;
   logic [NUM_CH-1:0]            ch_ctl_wr;
   logic [NUM_CH-1:0]            ch_ivl_wr;
   logic [NUM_CH-1:0]            ch_tick;
   logic [NUM_CH-1:0]            ch_expire;
   logic [NUM_CH-1:0]            ch_run;
   logic [NUM_CH-1:0]            ch_oneshot;
   logic [NUM_CH-1:0][CTL_W-1:0] ch_ctrl;
   logic [NUM_CH-1:0][CNT_W-1:0] ch_ivl;
   logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
   logic [DATA_W-1:0]            rd_mux;

   assign win      = addr[7:4];
   assign off      = addr[3:0];
   assign in_range = (addr >> 8) == '0;
   assign mask_wr  = wr_en && in_range && (addr[7:0] == ADDR_MASK);
   assign stat_wr  = wr_en && in_range && (addr[7:0] == ADDR_STAT);

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         assign ch_ctl_wr[g] = wr_en && in_range && (win == 4'(g + 1)) && (off == OFF_CTRL);
         assign ch_ivl_wr[g] = wr_en && in_range && (win == 4'(g + 1)) && (off == OFF_IVL);
         pit_channel #(
            .NUM_SRC (NUM_SRC),
            .CNT_W   (CNT_W),
            .DATA_W  (DATA_W)
         ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (src_tick),
            .ctl_wr   (ch_ctl_wr[g]),
            .ivl_wr   (ch_ivl_wr[g]),
            .wdata    (wdata),
            .ctrl_o   (ch_ctrl[g]),
            .ivl_o    (ch_ivl[g]),
            .cnt_o    (ch_cnt[g]),
            .tick_o   (ch_tick[g]),
            .expire_o (ch_expire[g])
         );
         assign ch_run[g]     = ch_ctrl[g][0];
         assign ch_oneshot[g] = ch_ctrl[g][7];
      end
   endgenerate

   assign clr = stat_wr ? wdata[NUM_CH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         stat_q <= '0;
      end else begin
         if (mask_wr) ien_q <= wdata[NUM_CH-1:0];
         stat_q <= (stat_q & ~clr) | ch_expire;
      end
   end

   assign irq = stat_q & ien_q;

   always_comb begin
      rd_mux = '0;
      if (in_range) begin
         if (addr[7:0] == ADDR_MASK)      rd_mux = DATA_W'(ien_q);
         else if (addr[7:0] == ADDR_STAT) rd_mux = DATA_W'(stat_q);
         for (int i = 0; i < NUM_CH; i++) begin
            if (win == 4'(i + 1)) begin
               case (off)
                  OFF_CTRL: rd_mux = DATA_W'(ch_ctrl[i]);
                  OFF_IVL:  rd_mux = DATA_W'(ch_ivl[i]);
                  OFF_CNT:  rd_mux = DATA_W'(ch_cnt[i]);
                  default:  rd_mux = '0;
               endcase
            end
         end
      end
   end

   generate
      if (REG_READ) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata_q <= '0;
            else if (rd_en) rdata_q <= rd_mux;
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_en ? rd_mux : '0;
      end
   endgenerate
endmodule

// File: rtl/pit_timer_bank_chk.sv
module pit_timer_bank_chk #(
   parameter int NUM_CH = 6,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        addr,
   input logic [NUM_CH-1:0]        wdata_lo,
   input logic [NUM_CH-1:0]        irq,
   input logic [NUM_CH-1:0]        stat_q,
   input logic [NUM_CH-1:0]        ch_ctl_wr,
   input logic [NUM_CH-1:0]        ch_tick,
   input logic [NUM_CH-1:0]        ch_expire,
   input logic [NUM_CH-1:0]        ch_run,
   input logic [NUM_CH-1:0]        ch_oneshot,
   input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
   input logic [NUM_CH-1:0][CNT_W-1:0] ch_ivl
);
   logic stat_wr;
   logic mask_wr;
   assign stat_wr = wr_en && (addr == ADDR_W'(pit_pkg::ADDR_STAT));
   assign mask_wr = wr_en && (addr == ADDR_W'(pit_pkg::ADDR_MASK));

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
         AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> ($past(ch_expire[i]) || $past(mask_wr))); // R1
         AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && wdata_lo[i] && !ch_expire[i]) |=> !irq[i]); // R2
         AST_EXPIRE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            ch_expire[i] |=> stat_q[i]); // R8
         AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_run[i] && ch_tick[i] && !ch_oneshot[i] && !ch_ctl_wr[i] && ch_cnt[i] == '0)
            |=> (ch_cnt[i] == $past(ch_ivl[i]))); // R8
         AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_expire[i] && ch_oneshot[i] && !ch_ctl_wr[i]) |=> !ch_run[i]); // R9
         AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_run[i] && !ch_ctl_wr[i]) |=> $stable(ch_cnt[i])); // R7
      end
   endgenerate
endmodule

bind pit_timer_bank pit_timer_bank_chk #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .addr       (addr),
   .wdata_lo   (wdata[NUM_CH-1:0]),
   .irq        (irq),
   .stat_q     (stat_q),
   .ch_ctl_wr  (ch_ctl_wr),
   .ch_tick    (ch_tick),
   .ch_expire  (ch_expire),
   .ch_run     (ch_run),
   .ch_oneshot (ch_oneshot),
   .ch_cnt     (ch_cnt),
   .ch_ivl     (ch_ivl)
);

// File: tb/tb_pit_timer_bank.sv
`timescale 1ns/1ps
module tb_pit_timer_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_tick = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [5:0]  irq;

   int errors = 0;
   int checks = 0;
   logic rd_pend = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   pit_timer_bank dut (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   always @(posedge clk) rd_pend <= rd_en;

   // monitor: pops the expected value of each completed read
   always @(negedge clk) begin
      if (rd_pend) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read: rdata=%h expected none", rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               errors++;
               $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(negedge clk); rd_en = 1'b1; addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic pulse(input logic [3:0] m, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); src_tick = m;
         @(negedge clk); src_tick = '0;
      end
   endtask

   task automatic chk_irq(input logic [5:0] e, input string t);
      @(negedge clk);
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s: irq=%h expected %h", t, irq, e);
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      rd(8'h10, 32'h04, "R11 ctrl0 reset");
      rd(8'h00, 32'h00, "R11 mask reset");
      rd(8'h04, 32'h00, "R11 status reset");
      rd(8'h68, 32'h00, "R11 count5 reset");
      chk_irq(6'h00, "R11 irq reset");
      // channel 0 on source 0
      wr(8'h14, 32'd100);
      rd(8'h18, 32'd0, "R10 reload write keeps count");
      wr(8'h10, 32'h03);
      rd(8'h10, 32'h01, "R4 load bit reads 0");
      rd(8'h18, 32'd100, "R6 load from reload");
      pulse(4'b0001, 3);
      rd(8'h18, 32'd97, "R10 live count");
      wr(8'h18, 32'd5);
      rd(8'h18, 32'd97, "R10 count write ignored");
      wr(8'h14, 32'd50);
      rd(8'h18, 32'd97, "R10 reload write keeps count");
      pulse(4'b0010, 2);
      rd(8'h18, 32'd97, "R5 unselected source");
      wr(8'h10, 32'h23);
      pulse(4'b0001, 3);
      rd(8'h18, 32'd50, "R5 divide by 4 partial");
      pulse(4'b0001, 1);
      rd(8'h18, 32'd49, "R5 divide by 4 step");
      wr(8'h10, 32'h20);
      pulse(4'b0001, 8);
      rd(8'h18, 32'd49, "R7 stopped holds");
      wr(8'h10, 32'h21);
      pulse(4'b0001, 4);
      rd(8'h18, 32'd48, "R7 resume");
      // channel 1 periodic on source 2
      wr(8'h24, 32'd3);
      wr(8'h20, 32'h0B);
      wr(8'h00, 32'h02);
      pulse(4'b0100, 2);
      chk_irq(6'h00, "R1 no irq before expiry");
      pulse(4'b0100, 1);
      rd(8'h28, 32'd0, "R8 count at zero");
      rd(8'h04, 32'h02, "R8 status set");
      chk_irq(6'h02, "R1 irq on expiry");
      pulse(4'b0100, 1);
      rd(8'h28, 32'd3, "R8 periodic wrap");
      wr(8'h04, 32'h01);
      rd(8'h04, 32'h02, "R2 zero bits kept");
      wr(8'h04, 32'h02);
      rd(8'h04, 32'h00, "R2 one bits cleared");
      chk_irq(6'h00, "R2 irq after clear");
      pulse(4'b0100, 2);
      @(negedge clk); wr_en = 1'b1; addr = 8'h04; wdata = 32'h02; src_tick = 4'b0100;
      @(negedge clk); wr_en = 1'b0; src_tick = '0;
      rd(8'h04, 32'h02, "R2 expiry beats clear");
      wr(8'h00, 32'h00);
      chk_irq(6'h00, "R1 mask gates irq");
      rd(8'h04, 32'h02, "R1 status kept when masked");
      // channel 2 one-shot on source 0
      wr(8'h34, 32'd2);
      wr(8'h30, 32'h83);
      pulse(4'b0001, 2);
      rd(8'h38, 32'd0, "R9 one-shot count zero");
      rd(8'h04, 32'h06, "R8 one-shot status");
      rd(8'h30, 32'h80, "R9 run bit cleared");
      pulse(4'b0001, 2);
      rd(8'h38, 32'd0, "R9 stays at zero");
      // channel 5, last window
      wr(8'h64, 32'd1);
      wr(8'h60, 32'h03);
      rd(8'h60, 32'h01, "R3 ch5 ctrl window");
      pulse(4'b0001, 1);
      rd(8'h04, 32'h26, "R3 ch5 status bit");
      wr(8'h00, 32'h20);
      chk_irq(6'h20, "R1 ch5 irq");
      // unmapped decode
      rd(8'h0C, 32'h0, "R12 unmapped global");
      wr(8'h70, 32'hFF);
      rd(8'h70, 32'h0, "R12 window past last channel");
      rd(8'h1C, 32'h0, "R12 unused channel offset");
      wr(8'h08, 32'hFF);
      rd(8'h00, 32'h20, "R12 write ignored mask");
      rd(8'h04, 32'h26, "R12 write ignored status");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R3 reads lost: pending=%0d expected 0", exp_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule